// File: doc/BRIEF.md
# Landing-Pad Control-Flow Integrity Tracker

This block guards forward-edge control flow in a core. It keeps a single "landing pad pending" bit. A qualifying indirect jump sets the bit. The next fetched instruction must then be a word-aligned landing-pad instruction. If that instruction carries a label, the label must equal the upper bits of register x7. A passing landing pad clears the bit. A failing fetch raises a software-check fault strobe, with a cause value and a trap-value code for the trap logic.

The pending bit is kept across exceptions. Taking a trap copies the bit into a saved bit owned by the target mode (machine or supervisor) and clears the live bit. A trap return puts the saved bit back only when landing pads are enabled at the privilege being resumed. It then clears the saved bit. The machine saved bit is also given as an aligned status word, so the status register can merge it at the position that the register width dictates.

Top module: `lp_cfi_tracker`

## Requirements
- R1: After reset the pending bit, both saved bits and the fault strobe are 0, and cause and tval read 0.
- R2: An indirect jump sets the pending bit (1 = pending, 0 = idle) on the next clock when landing pads are enabled at the current privilege and the source register index is not 1, 5 or 7.
- R3: An indirect jump whose source register is 1, 5 or 7, or which is made while landing pads are disabled, leaves the pending bit unchanged.
- R4: The enable is chosen by privilege (encoding 2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 never enabled): machine uses `mlpe_i`, supervisor uses `menv_lpe_i`, user uses `senv_lpe_i`, or `menv_lpe_i` when `HAS_SMODE` is 0.
- R5: While pending and enabled, a fetch is an encoding violation if PC bits [1:0] are nonzero, or instruction bits [6:0] differ from 7'b0010111, or bits [11:7] are nonzero. A violation drives `fault_o` high on the next clock with cause 18 and tval 2, and the pending bit stays 1.
- R6: While pending and enabled, a well-encoded landing pad with label bits [31:12] nonzero and different from `x7_hi_i` faults as in R5. A label of zero, or a label equal to `x7_hi_i`, clears the pending bit with no fault.
- R7: When the pending bit is 0, or landing pads are disabled at the current privilege, a fetch never faults and does not change the pending bit.
- R8: A trap copies the pending bit into the machine saved bit (`trap_to_m_i`=1) or into the supervisor saved bit (`trap_to_m_i`=0), and clears the pending bit.
- R9: On a return (`ret_is_m_i`=1 machine, 0 supervisor), the pending bit takes that mode's saved bit if landing pads are enabled at `ret_pp_i`, and 0 otherwise. The saved bit is then cleared.
- R10: Priority within one cycle is trap, then return, then jump arming, then landing-pad clear. A trap or a return also suppresses any fault from the same cycle.
- R11: `fault_o` is high for exactly one cycle per violating fetch, and cause and tval read 0 whenever `fault_o` is low.
- R12: `mstat_pelp_o` holds the machine saved bit at bit 41 when `XLEN` is 64, and at bit 9 (of the upper status half) when `XLEN` is 32. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege |
| mlpe_i | input | 1 | Machine-mode landing-pad enable |
| menv_lpe_i | input | 1 | Enable for supervisor (or user without S-mode) |
| senv_lpe_i | input | 1 | User-mode enable when S-mode exists |
| jmp_vld_i | input | 1 | Indirect jump retired |
| jmp_rs1_i | input | 5 | Source register index of the jump |
| fetch_vld_i | input | 1 | Instruction fetched for checking |
| fetch_pc_lo_i | input | 2 | PC bits [1:0] of that fetch |
| fetch_insn_i | input | 32 | Instruction bits |
| x7_hi_i | input | 20 | Bits [31:12] of register x7 |
| trap_vld_i | input | 1 | Trap taken |
| trap_to_m_i | input | 1 | Trap target is machine (1) or supervisor (0) |
| ret_vld_i | input | 1 | Trap return executed |
| ret_is_m_i | input | 1 | Machine return (1) or supervisor return (0) |
| ret_pp_i | input | 2 | Privilege being returned to |
| fault_o | output | 1 | Landing-pad fault strobe |
| fault_cause_o | output | 8 | Exception cause (18 on fault) |
| fault_tval_o | output | XLEN | Trap value (2 on fault) |
| elp_o | output | 1 | Live pending bit |
| mpelp_o | output | 1 | Machine saved bit |
| spelp_o | output | 1 | Supervisor saved bit |
| mstat_pelp_o | output | XLEN | Machine saved bit placed in a status word |

## Verification
Jumps are tried through the arming registers and through each exempt register. This separates the register filter from the enable path. Fetches after arming change one field at a time: misaligned PC, wrong opcode, nonzero rd, mismatched label, zero label and matching label. This shows each violation term on its own, and shows the wildcard label apart from a real match. Privilege sweeps with only one enable set show which enable bit each mode reads. Trap and return sequences, including a trap that lands in the same cycle as a jump, and returns to a disabled privilege, show that the save, the restore and the priority order are correct.

// File: rtl/lpcfi_pkg.sv
package lpcfi_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int unsigned CAUSE_W   = 8;
  localparam int unsigned LABEL_W   = 20;
  localparam int unsigned LABEL_LSB = 12;

  localparam logic [CAUSE_W-1:0] SW_CHECK_CAUSE = 8'd18;
  localparam int unsigned        LP_FAULT_CODE  = 2;

  localparam logic [6:0] LPAD_OPCODE = 7'b0010111;

  typedef struct packed {
    logic       pending;
    logic       m_saved;
    logic       s_saved;
  } lp_state_t;
endpackage

// File: rtl/lpcfi_enable.sv
module lpcfi_enable
  import lpcfi_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv_i,
  input  logic       mlpe_i,
  input  logic       menv_lpe_i,
  input  logic       senv_lpe_i,
  output logic       en_o
);
  always_comb begin
    unique case (priv_i)
      PRIV_M:  en_o = mlpe_i;
      PRIV_S:  en_o = menv_lpe_i;
      PRIV_U:  en_o = HAS_SMODE ? senv_lpe_i : menv_lpe_i;
      default: en_o = 1'b0;
    endcase
  end

  assert_m_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_M) |-> (en_o == mlpe_i));
  assert_reserved_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b10) |-> !en_o);
endmodule

// File: rtl/lpcfi_check.sv
module lpcfi_check
  import lpcfi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_vld_i,
  input  logic               en_i,
  input  logic               pending_i,
  input  logic [1:0]         pc_lo_i,
  input  logic [31:0]        insn_i,
  input  logic [LABEL_W-1:0] x7_hi_i,
  output logic               bad_o,
  output logic               pass_o
);
  logic               armed_fetch;
  logic               enc_bad;
  logic [LABEL_W-1:0] label;
  logic               label_bad;

  always_comb begin
    armed_fetch = fetch_vld_i && en_i && pending_i;
    label       = insn_i[LABEL_LSB +: LABEL_W];
    enc_bad     = (pc_lo_i != 2'b00) || (insn_i[6:0] != LPAD_OPCODE)
                  || (insn_i[11:7] != 5'd0);
    label_bad   = (label != '0) && (label != x7_hi_i);
    bad_o       = armed_fetch && (enc_bad || label_bad);
    pass_o      = armed_fetch && !enc_bad && !label_bad;
  end

  assert_idle_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending_i && en_i) |-> !(bad_o || pass_o));
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_o && pass_o));
endmodule

// File: rtl/lpcfi_state.sv
module lpcfi_state
  import lpcfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       pass_i,
  input  logic       bad_i,
  input  logic       trap_vld_i,
  input  logic       trap_to_m_i,
  input  logic       ret_vld_i,
  input  logic       ret_is_m_i,
  input  logic       ret_en_i,
  output lp_state_t  st_o,
  output logic       fault_o
);
  lp_state_t st_q, st_d;
  logic      fault_q, fault_d;
  logic      st_en;

  always_comb begin
    st_d    = st_q;
    fault_d = 1'b0;
    if (trap_vld_i) begin
      if (trap_to_m_i) st_d.m_saved = st_q.pending;
      else             st_d.s_saved = st_q.pending;
      st_d.pending = 1'b0;
    end else if (ret_vld_i) begin
      if (ret_is_m_i) begin
        st_d.pending = ret_en_i && st_q.m_saved;
        st_d.m_saved = 1'b0;
      end else begin
        st_d.pending = ret_en_i && st_q.s_saved;
        st_d.s_saved = 1'b0;
      end
    end else begin
      fault_d = bad_i;
      if (arm_i)       st_d.pending = 1'b1;
      else if (pass_i) st_d.pending = 1'b0;
    end
    st_en = trap_vld_i || ret_vld_i || arm_i || pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
      if (st_en) st_q <= st_d;
    end
  end

  assign st_o    = st_q;
  assign fault_o = fault_q;

  assert_trap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld_i |=> !st_q.pending);
  assert_trap_saves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld_i && trap_to_m_i) |=> (st_q.m_saved == $past(st_q.pending)));
  assert_ret_clears_saved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld_i && !trap_vld_i && ret_is_m_i) |=> !st_q.m_saved);
  assert_fault_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> st_q.pending);
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !trap_vld_i && !ret_vld_i) |=> st_q.pending);
  assert_trap_no_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld_i || ret_vld_i) |=> !fault_q);
endmodule

// File: rtl/lp_cfi_tracker.sv
module lp_cfi_tracker
  import lpcfi_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter bit          HAS_SMODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_i,
  input  logic               mlpe_i,
  input  logic               menv_lpe_i,
  input  logic               senv_lpe_i,
  input  logic               jmp_vld_i,
  input  logic [4:0]         jmp_rs1_i,
  input  logic               fetch_vld_i,
  input  logic [1:0]         fetch_pc_lo_i,
  input  logic [31:0]        fetch_insn_i,
  input  logic [LABEL_W-1:0] x7_hi_i,
  input  logic               trap_vld_i,
  input  logic               trap_to_m_i,
  input  logic               ret_vld_i,
  input  logic               ret_is_m_i,
  input  logic [1:0]         ret_pp_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o,
  output logic [XLEN-1:0]    fault_tval_o,
  output logic               elp_o,
  output logic               mpelp_o,
  output logic               spelp_o,
  output logic [XLEN-1:0]    mstat_pelp_o
);
  localparam int unsigned MPELP_POS = (XLEN == 64) ? 41 : 9;

  logic      cur_en, ret_en;
  logic      exempt, arm;
  logic      bad, pass;
  lp_state_t st;

  lpcfi_enable #(.HAS_SMODE(HAS_SMODE)) u_en_cur (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .mlpe_i(mlpe_i),
    .menv_lpe_i(menv_lpe_i), .senv_lpe_i(senv_lpe_i), .en_o(cur_en));

  lpcfi_enable #(.HAS_SMODE(HAS_SMODE)) u_en_ret (
    .clk(clk), .rst_n(rst_n), .priv_i(ret_pp_i), .mlpe_i(mlpe_i),
    .menv_lpe_i(menv_lpe_i), .senv_lpe_i(senv_lpe_i), .en_o(ret_en));

  always_comb begin
    exempt = (jmp_rs1_i == 5'd1) || (jmp_rs1_i == 5'd5) || (jmp_rs1_i == 5'd7);
    arm    = jmp_vld_i && cur_en && !exempt;
  end

  lpcfi_check u_check (
    .clk(clk), .rst_n(rst_n), .fetch_vld_i(fetch_vld_i), .en_i(cur_en),
    .pending_i(st.pending), .pc_lo_i(fetch_pc_lo_i), .insn_i(fetch_insn_i),
    .x7_hi_i(x7_hi_i), .bad_o(bad), .pass_o(pass));

  lpcfi_state u_state (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .pass_i(pass), .bad_i(bad),
    .trap_vld_i(trap_vld_i), .trap_to_m_i(trap_to_m_i),
    .ret_vld_i(ret_vld_i), .ret_is_m_i(ret_is_m_i), .ret_en_i(ret_en),
    .st_o(st), .fault_o(fault_o));

  assign elp_o         = st.pending;
  assign mpelp_o       = st.m_saved;
  assign spelp_o       = st.s_saved;
  assign fault_cause_o = fault_o ? SW_CHECK_CAUSE : '0;
  assign fault_tval_o  = fault_o ? XLEN'(LP_FAULT_CODE) : '0;

  generate
    if (XLEN == 64 || XLEN == 32) begin : g_view
      assign mstat_pelp_o = XLEN'(st.m_saved) << MPELP_POS;
    end else begin : g_noview
      assign mstat_pelp_o = '0;
    end
  endgenerate

  assert_exempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_vld_i && exempt && !fetch_vld_i && !trap_vld_i && !ret_vld_i)
      |=> (elp_o == $past(elp_o)));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> (fault_cause_o == '0 && fault_tval_o == '0));
  assert_view_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mstat_pelp_o) == 32'(mpelp_o));
endmodule

// File: tb/lp_cfi_tracker_test.sv
module lp_cfi_tracker_test;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  priv = 2'b11;
  logic        mlpe = 1'b0, menv = 1'b0, senv = 1'b0;
  logic        jv = 1'b0;
  logic [4:0]  rs1 = '0;
  logic        fv = 1'b0;
  logic [1:0]  pclo = '0;
  logic [31:0] insn = '0;
  logic [19:0] x7h = '0;
  logic        tv = 1'b0, tm = 1'b0, rv = 1'b0, rm = 1'b0;
  logic [1:0]  rpp = '0;

  logic            fault, elp, mpelp, spelp;
  logic [7:0]      cause;
  logic [XLEN-1:0] tval, view;

  lp_cfi_tracker #(.XLEN(XLEN), .HAS_SMODE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .mlpe_i(mlpe),
    .menv_lpe_i(menv), .senv_lpe_i(senv), .jmp_vld_i(jv), .jmp_rs1_i(rs1),
    .fetch_vld_i(fv), .fetch_pc_lo_i(pclo), .fetch_insn_i(insn),
    .x7_hi_i(x7h), .trap_vld_i(tv), .trap_to_m_i(tm), .ret_vld_i(rv),
    .ret_is_m_i(rm), .ret_pp_i(rpp), .fault_o(fault), .fault_cause_o(cause),
    .fault_tval_o(tval), .elp_o(elp), .mpelp_o(mpelp), .spelp_o(spelp),
    .mstat_pelp_o(view));

  int checks = 0;
  int errors = 0;
  bit m_elp = 0, m_mp = 0, m_sp = 0, m_fault = 0;

  function automatic bit lp_on(input logic [1:0] p);
    if (p == 2'b11) return mlpe;
    if (p == 2'b01) return menv;
    if (p == 2'b00) return senv;
    return 0;
  endfunction

  function automatic logic [31:0] lpad(input logic [19:0] lbl);
    return {lbl, 5'd0, 7'h17};
  endfunction

  task automatic expect1(input string tag, input string what,
                         input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [XLEN-1:0] exp_view;
    checks++;
    exp_view = '0;
    exp_view[41] = m_mp;
    expect1(tag, "elp", elp, m_elp);
    expect1(tag, "mpelp", mpelp, m_mp);
    expect1(tag, "spelp", spelp, m_sp);
    expect1(tag, "fault", fault, m_fault);
    if (cause !== (m_fault ? 8'd18 : 8'd0) || tval !== (m_fault ? 64'd2 : 64'd0)) begin
      errors++;
      $display("FAIL %s cause/tval actual=%0d/%0d expected=%0d/%0d", tag,
               cause, tval, m_fault ? 18 : 0, m_fault ? 2 : 0);
    end
    if (view !== exp_view) begin
      errors++;
      $display("FAIL R12 %s view actual=%h expected=%h", tag, view, exp_view);
    end
  endtask

  // One clock: inputs already set; model steps at the edge, compare after.
  task automatic cyc(input string tag);
    bit en, bad, ok, nf;
    @(posedge clk);
    en = lp_on(priv);
    bad = 0; ok = 0; nf = 0;
    if (fv && en && m_elp) begin
      if (pclo != 0 || insn[6:0] != 7'h17 || insn[11:7] != 0 ||
          (insn[31:12] != 0 && insn[31:12] != x7h)) bad = 1;
      else ok = 1;
    end
    if (tv) begin
      if (tm) m_mp = m_elp; else m_sp = m_elp;
      m_elp = 0;
    end else if (rv) begin
      if (rm) begin m_elp = lp_on(rpp) && m_mp; m_mp = 0; end
      else    begin m_elp = lp_on(rpp) && m_sp; m_sp = 0; end
    end else begin
      nf = bad;
      if (jv && en && rs1 != 1 && rs1 != 5 && rs1 != 7) m_elp = 1;
      else if (ok) m_elp = 0;
    end
    m_fault = nf;
    @(negedge clk);
    compare(tag);
    jv = 0; fv = 0; tv = 0; rv = 0;
  endtask

  task automatic jump(input logic [4:0] r, input string tag);
    jv = 1; rs1 = r; cyc(tag);
  endtask

  task automatic fetch(input logic [1:0] pl, input logic [31:0] in,
                       input logic [19:0] x, input string tag);
    fv = 1; pclo = pl; insn = in; x7h = x; cyc(tag);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    cyc("R1 idle");

    priv = 2'b11; mlpe = 1;
    jump(5'd10, "R2 arm x10");
    fetch(2'b00, lpad(20'h0), 20'h12345, "R6 zero label clears");
    cyc("R11 idle");
    jump(5'd1, "R3 x1 exempt");
    jump(5'd5, "R3 x5 exempt");
    jump(5'd7, "R3 x7 exempt");

    jump(5'd6, "R2 arm x6");
    fetch(2'b10, lpad(20'h0), 20'h0, "R5 misaligned");
    cyc("R11 pulse ends");
    fetch(2'b00, 32'h0000_0013, 20'h0, "R5 wrong opcode");
    fetch(2'b00, {20'h0, 5'd3, 7'h17}, 20'h0, "R5 rd nonzero");
    fetch(2'b00, lpad(20'hABCDE), 20'hABCDF, "R6 label mismatch");
    fetch(2'b00, lpad(20'hABCDE), 20'hABCDE, "R6 label match");

    jump(5'd9, "R2 arm again");
    mlpe = 0;
    fetch(2'b01, 32'h0, 20'h0, "R7 disabled no check");
    mlpe = 1;
    fetch(2'b00, lpad(20'h1), 20'h1, "R6 clear");
    fetch(2'b11, 32'h0, 20'h0, "R7 idle fetch");
    mlpe = 0;
    jump(5'd10, "R3 disabled no arm");

    priv = 2'b01; menv = 1;
    jump(5'd12, "R4 S uses menv");
    fetch(2'b00, lpad(20'h0), 20'h0, "R4 S clear");
    priv = 2'b00; menv = 0; senv = 1;
    jump(5'd12, "R4 U uses senv");
    fetch(2'b00, lpad(20'h0), 20'h0, "R4 U clear");
    senv = 0; menv = 1;
    jump(5'd12, "R4 U ignores menv");
    priv = 2'b10; mlpe = 1; menv = 1; senv = 1;
    jump(5'd12, "R4 reserved off");

    priv = 2'b00;
    jump(5'd12, "R2 arm U");
    tv = 1; tm = 1; cyc("R8 trap to M saves");
    priv = 2'b11;
    rv = 1; rm = 1; rpp = 2'b00; cyc("R9 mret restores");
    tv = 1; tm = 0; cyc("R8 trap to S saves");
    senv = 0;
    rv = 1; rm = 0; rpp = 2'b00; cyc("R9 sret disabled target");
    senv = 1; priv = 2'b11;
    jump(5'd14, "R2 arm M");
    tv = 1; tm = 1; jv = 1; rs1 = 5'd14; cyc("R10 trap beats jump");
    rv = 1; rm = 1; rpp = 2'b11; jv = 1; rs1 = 5'd1; cyc("R10 ret restores");
    rv = 1; rm = 1; rpp = 2'b11; fv = 1; pclo = 2'b01; cyc("R10 ret hides fault");
    fetch(2'b01, 32'h0, 20'h0, "R5 fault after ret");
    jump(5'd20, "R10 arm during fault hold");
    cyc("R11 final idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule